// File: doc/BRIEF.md
# Latch-or-Register Bus Buffer

This block is a parameterised buffer for address and control lines on a memory module. One control input sets how every bit behaves. When it is low, the bits are transparent and the output follows the input with no clock involved. When it is high, the output shows a stored copy of the input, and that copy is refreshed on each rising clock edge. Between edges the output holds its value.

An active-low output enable releases the output bus to high impedance. A separate driven flag reports whether the bus is being driven, so the state can be checked without resolving a tri-state net. The stored copy keeps loading on every rising edge while the bus is released. The storage also loads in transparent mode. As a result, when the outputs are enabled again, or when the mode changes to registered, the output shows the most recent sample at once. An active-low synchronous reset clears the stored copy to zero.

Top module: `lrb_bus_buffer`

## Requirements
- R1: While `outEnN` is 1, `busDriven` is 0 and `busOut` is released to high impedance, whatever the values on the other inputs.
- R2: While `outEnN` is 0 and `latchEn` is 0, `busOut` equals `din` in the same time step with no clock edge needed, and `busDriven` is 1.
- R3: While `outEnN` is 0 and `latchEn` is 1, `busOut` takes the value that `din` had at the most recent rising edge of `clk`.
- R4: While `latchEn` is 1, changes on `din` between rising edges leave `busOut` unchanged until the next rising edge.
- R5: The stored copy loads `din` on every rising edge while `rstN` is 1, in both modes and whether or not the bus is driven. When `outEnN` falls with `latchEn` at 1, the sample taken while the bus was released appears at once.
- R6: When `latchEn` goes from 0 to 1 between edges, `busOut` shows the value `din` had at the last rising edge before the change, and keeps it until the next rising edge.
- R7: A rising edge with `rstN` at 0 clears the stored copy to all zeros. The transparent path is unaffected, so with `latchEn` at 0 `busOut` still follows `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; storage loads on the rising edge |
| rstN | input | 1 | Active-low synchronous clear of the stored copy |
| latchEn | input | 1 | 0 selects transparent mode, 1 selects registered mode |
| outEnN | input | 1 | Active-low output enable; 1 releases the bus |
| din | input | WIDTH (24) | Data input bus |
| busOut | output | WIDTH (24) | Tri-state output bus |
| busDriven | output | 1 | 1 when `busOut` is being driven |

## Verification
Results on the transparent path and the float control are due in the same time step as their inputs. The bench therefore samples them one nanosecond after changing the inputs, with no clock edge in between. Registered results, including the clear, are due just after the first rising edge that follows the stimulus. The bench samples these one nanosecond after that edge. The hold, re-enable and mode-switch checks change inputs mid-cycle and sample before the next edge, to show that the output has not moved yet.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
package lrb_pkg;
  typedef struct packed {
    logic clear;     // synchronous clear of storage this edge
    logic load;      // storage captures input this edge
    logic passThru;  // output follows input combinationally
    logic drive;     // output bus is driven
  } lrbStrobes_t;
endpackage

// File: rtl/lrb_control.sv
`timescale 1ns/1ps
module lrb_control
  import lrb_pkg::*;
(
  input  logic        rstN,
  input  logic        latchEn,
  input  logic        outEnN,
  output lrbStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.clear    = ~rstN;
    strobes.load     = rstN;      // capture continues in either mode and while floated
    strobes.passThru = ~latchEn;
    strobes.drive    = ~outEnN;
  end
endmodule

// File: rtl/lrb_datapath.sv
`timescale 1ns/1ps
module lrb_datapath
  import lrb_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  lrbStrobes_t      strobes,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] storedQ,
  output logic [WIDTH-1:0] dataOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (strobes.clear)     storedQ[b] <= 1'b0;
      else if (strobes.load) storedQ[b] <= din[b];
    end
    assign dataOut[b] = strobes.passThru ? din[b] : storedQ[b];
  end
endmodule

// File: rtl/lrb_bus_buffer.sv
`timescale 1ns/1ps
module lrb_bus_buffer
  import lrb_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             latchEn,
  input  logic             outEnN,
  input  logic [WIDTH-1:0] din,
  output wire  [WIDTH-1:0] busOut,
  output logic             busDriven
);
  lrbStrobes_t      strobes;
  logic [WIDTH-1:0] storedQ;
  logic [WIDTH-1:0] dataOut;

  lrb_control u_ctl (
    .rstN    (rstN),
    .latchEn (latchEn),
    .outEnN  (outEnN),
    .strobes (strobes)
  );

  lrb_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .din     (din),
    .storedQ (storedQ),
    .dataOut (dataOut)
  );

  assign busOut    = strobes.drive ? dataOut : {WIDTH{1'bz}};
  assign busDriven = strobes.drive;
endmodule

// File: rtl/lrb_checker.sv
`timescale 1ns/1ps
module lrb_checker #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             latchEn,
  input logic             outEnN,
  input logic [WIDTH-1:0] din,
  input wire  [WIDTH-1:0] busOut,
  input logic             busDriven,
  input logic [WIDTH-1:0] storedQ
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_float_R1: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !busDriven);

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!outEnN && !latchEn) |-> (busDriven && busOut == din));

  assert_registered_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(rstN) && !outEnN && latchEn) |-> (busOut == $past(din)));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(rstN)) |-> (storedQ == $past(din)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(rstN)) |-> (storedQ == '0));
endmodule

bind lrb_bus_buffer lrb_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .latchEn   (latchEn),
  .outEnN    (outEnN),
  .din       (din),
  .busOut    (busOut),
  .busDriven (busDriven),
  .storedQ   (storedQ)
);

// File: tb/lrb_bus_buffer_test.sv
`timescale 1ns/1ps
module lrb_bus_buffer_test;
  localparam int W = 24;
  // {rstN, latchEn, outEnN, din, expDriven, expOut}
  localparam int VW = 3 + W + 1 + W;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b010, 24'hA5A5A5, 1'b1, 24'h000000},
    {3'b110, 24'h123456, 1'b1, 24'h123456},
    {3'b100, 24'h0F0F0F, 1'b1, 24'h0F0F0F},
    {3'b101, 24'hFFFFFF, 1'b0, 24'h000000},
    {3'b110, 24'hABCDEF, 1'b1, 24'hABCDEF},
    {3'b111, 24'h000001, 1'b0, 24'h000000},
    {3'b110, 24'h777777, 1'b1, 24'h777777},
    {3'b000, 24'hC3C3C3, 1'b1, 24'hC3C3C3}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         latchEn = 1'b0;
  logic         outEnN = 1'b1;
  logic [W-1:0] din = '0;
  wire  [W-1:0] busOut;
  logic         busDriven;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lrb_bus_buffer #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .latchEn(latchEn), .outEnN(outEnN),
    .din(din), .busOut(busOut), .busDriven(busDriven)
  );

  task automatic check(input string req, input logic expDrv, input logic [W-1:0] expOut);
    checks++;
    if (busDriven !== expDrv) begin
      fails++;
      $display("FAIL %s: busDriven=%0b expected %0b", req, busDriven, expDrv);
    end else if (expDrv && busOut !== expOut) begin
      fails++;
      $display("FAIL %s: busOut=%h expected %h", req, busOut, expOut);
    end
  endtask

  task automatic edgeThenSettle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    edgeThenSettle();
    edgeThenSettle();
    // reset state: released bus
    check("R1", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      {rstN, latchEn, outEnN, din} = v[VW-1 -: 3+W];
      edgeThenSettle();
      if (!v[W]) tag = "R1";
      else if (!v[VW-1]) tag = "R7";
      else if (v[VW-2]) tag = "R3";
      else tag = "R2";
      check(tag, v[W], v[W-1:0]);
    end

    // R7: storage was cleared by last vector; switching to registered shows zero
    latchEn = 1'b1; #1;
    check("R7", 1'b1, 24'h000000);
    rstN = 1'b1;

    // R2: transparent follows input with no clock edge
    latchEn = 1'b0; din = 24'h135790; #1;
    check("R2", 1'b1, 24'h135790);
    din = 24'h2468AC; #1;
    check("R2", 1'b1, 24'h2468AC);

    // R4: hold between edges in registered mode
    latchEn = 1'b1; din = 24'h111111;
    edgeThenSettle();
    check("R3", 1'b1, 24'h111111);
    din = 24'h222222; #1;
    check("R4", 1'b1, 24'h111111);
    edgeThenSettle();
    check("R3", 1'b1, 24'h222222);

    // R5: storage loads while floated, shown immediately on re-enable
    outEnN = 1'b1; din = 24'h3C3C3C;
    edgeThenSettle();
    check("R1", 1'b0, '0);
    din = 24'h999999; outEnN = 1'b0; #1;
    check("R5", 1'b1, 24'h3C3C3C);

    // R6: switch transparent -> registered keeps value sampled at last edge
    latchEn = 1'b0; din = 24'h5A5A5A;
    edgeThenSettle();
    check("R2", 1'b1, 24'h5A5A5A);
    din = 24'h000FFF; latchEn = 1'b1; #1;
    check("R6", 1'b1, 24'h5A5A5A);
    edgeThenSettle();
    check("R6", 1'b1, 24'h000FFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule